// File: doc/BRIEF.md
# Four-Function Add/Subtract/Logic ALU

A purely combinational arithmetic-logic unit over two operand words of a parameterised width (32 bits by default). A two-bit function code picks one of four operations. The result is a word of the operand width, valid once the inputs have settled. There is no clock, no reset and no stored state.

Addition and subtraction share one adder, built as a ripple chain of one-bit full adders. For subtraction a 2:1 selector gives the adder the bitwise complement of the second operand. The same control line drives the chain's carry-in to 1, so the adder computes the first operand plus the two's-complement negation of the second. The carry out of the top stage is dropped, so results wrap modulo 2^W. A second selection level picks the adder word, a bitwise AND or a bitwise OR.

Top module: `quad_op_alu`

## Requirements
- R1: With funcSel = 2'b00, result equals (opA + opB) modulo 2^W.
- R2: With funcSel = 2'b01, result equals (opA - opB) modulo 2^W, computed as opA + ~opB + 1. For example 0 - 1 gives all ones.
- R3: With funcSel = 2'b10, each bit of result is the AND of the same bits of opA and opB.
- R4: With funcSel = 2'b11, each bit of result is the OR of the same bits of opA and opB.
- R5: The carry out of the most significant adder stage is discarded. For example, all-ones plus 1 gives 0 and the result stays W bits wide.
- R6: The block is combinational. A change on funcSel alone, with the operands held, changes result to the newly selected function without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W | First operand (minuend for subtraction) |
| opB | input | W | Second operand (subtrahend for subtraction) |
| funcSel | input | 2 | Function code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | W | Selected function of opA and opB, W bits |

## Verification
The block holds no state, so any fault in the decoded strobes or the carry chain shows at result in the same settle window as the input change. An inverted carry-in shows as an off-by-one on adds or subtracts. A broken chain link shows only when a carry must cross that stage. The vectors therefore include long carry runs (all ones plus one, zero minus one) and random words. Each vector is compared against a behavioural model as soon as its inputs settle.

// File: rtl/quad_op_alu_pkg.sv
package quad_op_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } aluFunc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic invertB;   // feed ~opB into the adder
    logic carryIn;   // least significant carry-in
    logic pickLogic; // take a logic word instead of the adder word
    logic pickOr;    // among logic words, take OR rather than AND
  } aluStrobe_t;

endpackage

// File: rtl/quad_op_alu_fa.sv
module quad_op_alu_fa (
  input  logic bitA,
  input  logic bitB,
  input  logic carryI,
  output logic sumO,
  output logic carryO
);
  logic halfSum;

  always_comb begin
    halfSum = bitA ^ bitB;
    sumO    = halfSum ^ carryI;
    carryO  = (bitA & bitB) | (halfSum & carryI);
  end
endmodule

// File: rtl/quad_op_alu_ctrl.sv
module quad_op_alu_ctrl
  import quad_op_alu_pkg::*;
(
  input  logic [1:0] funcSel,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (aluFunc_e'(funcSel))
      FN_ADD: begin
        strobe.invertB = 1'b0;
        strobe.carryIn = 1'b0;
      end
      FN_SUB: begin
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
      end
      FN_AND: strobe.pickLogic = 1'b1;
      FN_OR: begin
        strobe.pickLogic = 1'b1;
        strobe.pickOr    = 1'b1;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/quad_op_alu_dp.sv
module quad_op_alu_dp
  import quad_op_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] result
);
  logic [W-1:0] adderB;
  logic [W-1:0] adderSum;
  logic [W:0]   carryChain;
  logic [W-1:0] andWord;
  logic [W-1:0] orWord;
  logic [W-1:0] logicWord;
  logic         droppedCarry;

  // 2:1 selector: plain or complemented second operand
  always_comb adderB = strobe.invertB ? ~opB : opB;

  assign carryChain[0] = strobe.carryIn;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    quad_op_alu_fa u_fa (
      .bitA   (opA[i]),
      .bitB   (adderB[i]),
      .carryI (carryChain[i]),
      .sumO   (adderSum[i]),
      .carryO (carryChain[i+1])
    );
  end

  // Top carry is intentionally unused: results wrap modulo 2^W
  assign droppedCarry = carryChain[W];

  always_comb begin
    andWord   = opA & opB;
    orWord    = opA | opB;
    logicWord = strobe.pickOr ? orWord : andWord;
    result    = strobe.pickLogic ? logicWord : adderSum;
  end

  always_comb begin
    if (!$isunknown({opA, opB, strobe})) begin
      AST_CHAIN_BOTTOM: assert ({droppedCarry, adderSum} ==
                                ({1'b0, opA} + {1'b0, adderB} + {{W{1'b0}}, strobe.carryIn}))
        else $error("ripple chain disagrees with wide sum"); // R5
    end
  end
endmodule

// File: rtl/quad_op_alu.sv
module quad_op_alu
  import quad_op_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [1:0]   funcSel,
  output logic [W-1:0] result
);
  aluStrobe_t strobe;

  quad_op_alu_ctrl u_ctrl (
    .funcSel (funcSel),
    .strobe  (strobe)
  );

  quad_op_alu_dp #(.W(W)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result)
  );

  always_comb begin
    if (!$isunknown({opA, opB, funcSel})) begin
      if (funcSel == 2'b00)
        AST_ADD_WRAP: assert (result == W'(opA + opB))
          else $error("add mismatch"); // R1
      if (funcSel == 2'b01)
        AST_SUB_WRAP: assert (result == W'(opA - opB))
          else $error("sub mismatch"); // R2
      if (funcSel == 2'b10)
        AST_AND_BITS: assert (result == (opA & opB))
          else $error("and mismatch"); // R3
      if (funcSel == 2'b11)
        AST_OR_BITS: assert (result == (opA | opB))
          else $error("or mismatch"); // R4
    end
  end
endmodule

// File: tb/test_quad_op_alu.sv
module test_quad_op_alu;
  localparam int W = 32;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [1:0]   funcSel = 2'b00;
  logic [W-1:0] result;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_op_alu #(.W(W)) i_quad_op_alu (
    .opA(opA), .opB(opB), .funcSel(funcSel), .result(result)
  );

  function automatic longint model(longint a, longint b, int f);
    case (f)
      0: return (a + b) & MASK;
      1: return (a + (MASK + 1) - b) & MASK;
      2: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic apply(input longint a, input longint b, input int f, input string req);
    longint exp;
    @(posedge clk);
    #1;
    opA = W'(a); opB = W'(b); funcSel = 2'(f);
    #2;
    exp = model(a & MASK, b & MASK, f);
    vectors++;
    if (longint'(result) != exp) begin
      misses++;
      $display("FAIL %s: sel=%0d a=%h b=%h actual=%h expected=%h",
               req, f, a, b, result, exp[W-1:0]);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // idle state: zero operands, add
    apply(0, 0, 0, "R1");
    apply(13, 6, 0, "R1");
    apply(64'h7FFF_FFFF, 1, 0, "R1");
    apply(MASK, 1, 0, "R5");          // carry out dropped -> 0
    apply(MASK, MASK, 0, "R5");       // wraps to all ones minus one
    apply(0, 1, 1, "R2");             // 0 - 1 -> all ones
    apply(19, 6, 1, "R2");
    apply(5, 5, 1, "R2");
    apply(0, MASK, 1, "R5");
    apply(64'hF0F0_F0F0, 64'hFF00_FF00, 2, "R3");
    apply(MASK, 0, 2, "R3");
    apply(64'hF0F0_F0F0, 64'h0F0F_0000, 3, "R4");
    apply(0, 0, 3, "R4");
    // R6: hold operands, step only funcSel
    for (int f = 0; f < 4; f++) apply(64'hA5A5_1234, 64'h0F0F_FFFF, f, "R6");
    for (int n = 0; n < 4000; n++) begin
      longint a, b;
      a = longint'($urandom) & MASK;
      b = longint'($urandom) & MASK;
      case (n % 4)
        0: apply(a, b, 0, "R1");
        1: apply(a, b, 1, "R2");
        2: apply(a, b, 2, "R3");
        default: apply(a, b, 3, "R4");
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule